// File: doc/BRIEF.md
# Serial 0-0-1 Sequence Detector

This block watches a single-bit serial stream `x` that is sampled on every rising clock edge. It flags the moment the stream completes the sequence 0, 0, 1. The flag `y` is a Mealy output: it is a function of the stored state and of the present value of `x`. It therefore goes high in the same cycle that the final 1 is presented, with no wait for the clock edge that samples that 1. Matches may overlap, so a zero that ends one attempt can begin the next. A run of zeros longer than two still counts as the required pair.

Two D flip-flops hold three states, with codes given as {Q1,Q0}:
- 00: nothing useful seen.
- 01: one 0 seen.
- 10: at least two 0s seen.

The next state and the flag come from fixed, minimised sum-of-products equations, and those equations treat the spare code 11 as a don't-care. The reset is synchronous and active-low. While reset is low the flag is held at 0.

Top module: `pattern001_detector`

## Requirements
- R1: A rising edge with `rst_n` low puts the machine in state 00. While `rst_n` is low, `y` is 0 whatever `x` is. After reset is released, the first 1 on `x` does not raise `y`.
- R2: When `rst_n` is high, `y` is 1 exactly when the state is 10 (at least two 0s sampled) and the live `x` is 1.
- R3: From state 00, a sampled 0 moves to 01 and a sampled 1 stays in 00. The flag is 0 in both cases. If the register ever holds 11, it leaves 11 at the next edge.
- R4: From state 01, a sampled 0 moves to 10 and a sampled 1 returns to 00. The flag is 0 in both cases.
- R5: From state 10, a sampled 0 stays in 10. A sampled 1 returns to 00, and the flag is 1 during that cycle.
- R6: Matches overlap. The stream 0,0,1,0,0,1 flags twice. The stream 0,0,0,1 flags once, on its last bit.
- R7: The flag follows changes of `x` between clock edges without waiting for an edge. Only the value of `x` at the rising edge decides the next state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x | input | 1 | Serial data bit |
| y | output | 1 | Mealy match flag |

## Verification
Two functions can fall in the same cycle: reset and a completed match. The bench provokes this by bringing the machine to state 10, then pulling `rst_n` low while it drives `x` to 1. It expects `y` to stay 0, and expects the first 1 after release to give no flag. A second coincidence is a match together with re-arming on the same edge. The overlapping streams in the vector table cover this, where the zero right after a flag must begin the next match. On every cycle of a random stream, including random reset pulses, the flag is compared against a case-statement model of the state table.

// File: rtl/pr_pkg.sv
// Package: shared constants for the serial 0-0-1 detector.
// Assumes the fixed two-bit state encoding; code 11 is unused.
package pr_pkg;
    localparam int STATE_W = 2;
    localparam int Q1_BIT  = 1;
    localparam int Q0_BIT  = 0;

    localparam logic [STATE_W-1:0] ST_IDLE   = 2'b00; // no useful history
    localparam logic [STATE_W-1:0] ST_ONE    = 2'b01; // one zero seen
    localparam logic [STATE_W-1:0] ST_TWO    = 2'b10; // two or more zeros seen
    localparam logic [STATE_W-1:0] ST_UNUSED = 2'b11; // spare code, don't-care
endpackage

// File: rtl/pr_next_state.sv
// Module: next-state logic as minimised sum-of-products.
// Assumes code 11 was a don't-care during minimisation; from 11 it yields {~x,0}.
module pr_next_state
    import pr_pkg::*;
(
    input  logic [STATE_W-1:0] q,
    input  logic               x,
    output logic [STATE_W-1:0] d
);
    // Flip-flop input equations.
    always_comb begin
        d[Q1_BIT] = (~x & q[Q0_BIT]) | (~x & q[Q1_BIT]);
        d[Q0_BIT] = ~q[Q1_BIT] & ~q[Q0_BIT] & ~x;
    end
endmodule

// File: rtl/pr_output.sv
// Module: Mealy flag logic, y = Q1 & x, forced low during reset.
// Assumes x is the live input, so y may change between clock edges.
module pr_output
    import pr_pkg::*;
(
    input  logic [STATE_W-1:0] q,
    input  logic               x,
    input  logic               rst_n,
    output logic               y
);
    // Product term for the match, gated by reset.
    always_comb begin
        y = rst_n & q[Q1_BIT] & x;
    end
endmodule

// File: rtl/pr_state_reg.sv
// Module: two-flop state register with synchronous active-low reset.
// Assumes d comes from the SOP equations; x is used only by the guards below.
module pr_state_reg
    import pr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               x,
    input  logic [STATE_W-1:0] d,
    output logic [STATE_W-1:0] q
);
    // Capture the next state, or return to idle under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= ST_IDLE;
        else        q <= d;
    end

    // The first active cycle after reset starts from idle.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (q == ST_IDLE));

    // Idle: a 0 moves to one-zero, a 1 stays idle.
    assert_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q == ST_IDLE) |=> (q == ($past(x) ? ST_IDLE : ST_ONE)));

    // The spare code is left within one clock.
    assert_leave_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q == ST_UNUSED) |=> (q != ST_UNUSED));

    // One-zero: a 0 moves to two-zero, a 1 goes back to idle.
    assert_from_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q == ST_ONE) |=> (q == ($past(x) ? ST_IDLE : ST_TWO)));

    // Two-zero: a 0 holds, a 1 goes back to idle.
    assert_from_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q == ST_TWO) |=> (q == ($past(x) ? ST_IDLE : ST_TWO)));
endmodule

// File: rtl/pattern001_detector.sv
// Module: top of the serial 0-0-1 Mealy detector with overlapping matches.
// Assumes x is synchronous to clk at the rising edge; y is combinational from x.
module pattern001_detector
    import pr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic y
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    pr_next_state u_next (
        .q (state_q),
        .x (x),
        .d (state_d)
    );

    pr_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (x),
        .d     (state_d),
        .q     (state_q)
    );

    pr_output u_out (
        .q     (state_q),
        .x     (x),
        .rst_n (rst_n),
        .y     (y)
    );

    // A flag at an edge implies the two-zero state with a sampled 1.
    assert_flag_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        y |-> (state_q == ST_TWO) && x);

    // After a flag the machine re-arms from idle, so the next match may overlap.
    assert_rearm_after_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        y |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_pattern001_detector.sv
`timescale 1ns/1ps
// Bench: a vector table, directed reset and mid-cycle tests, then a random
// stream compared against a case-statement model.
module tb_pattern001_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x = 1'b0;
    logic y;
    int   n_checks = 0;
    int   n_fail = 0;
    logic [1:0] m_st = 2'b00;

    pattern001_detector dut (.clk(clk), .rst_n(rst_n), .x(x), .y(y));

    always #2.5 clk = ~clk; // 200 MHz

    // Reference model of the state table (00 idle, 01 one zero, 10 two zeros).
    always @(posedge clk) begin
        if (!rst_n) m_st <= 2'b00;
        else begin
            case (m_st)
                2'b00:   m_st <= x ? 2'b00 : 2'b01;
                2'b01:   m_st <= x ? 2'b00 : 2'b10;
                default: m_st <= x ? 2'b00 : 2'b10;
            endcase
        end
    end

    // Compare y with an expected value and count the result.
    task automatic check(input logic exp, input string tag);
        n_checks++;
        if (y !== exp) begin
            n_fail++;
            $display("FAIL %s: y=%b expected=%b at %0t", tag, y, exp, $time);
        end
    endtask

    // Drive x just after the falling edge, then sample y.
    task automatic step(input logic xv, input logic exp, input string tag);
        @(negedge clk);
        x = xv;
        #1;
        check(exp, tag);
    endtask

    // Vectors as {x, expected y}.
    localparam logic [1:0] VEC [21] = '{
        2'b00, 2'b00, 2'b11, 2'b10,          // 0,0,1 then 1
        2'b00, 2'b00, 2'b00, 2'b11,          // 0,0,0,1 -> one flag
        2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, // 0,0,1,0,0,1 -> two flags
        2'b00, 2'b10, 2'b00, 2'b00, 2'b11,   // 0,1 breaks, then 0,0,1
        2'b10, 2'b10                         // ones stay idle
    };

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset state, with x high while reset is held.
        x = 1'b1;
        #1;
        check(1'b0, "R1 reset at time zero");
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check(1'b0, "R1 y low in reset with x=1");
        rst_n = 1'b1;
        x = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 transitions and overlapping matches.
        for (int i = 0; i < 21; i++) begin
            step(VEC[i][1], VEC[i][0], $sformatf("R2 R3 R4 R5 R6 vector %0d", i));
        end

        // R1 and a match in the same cycle: reset wins.
        step(1'b0, 1'b0, "R4 first zero");
        step(1'b0, 1'b0, "R5 second zero");
        @(negedge clk);
        rst_n = 1'b0;
        x = 1'b1;
        #1;
        check(1'b0, "R1 reset masks match");
        @(negedge clk);
        rst_n = 1'b1;
        x = 1'b1;
        #1;
        check(1'b0, "R1 idle after reset, no flag");

        // R7: y follows x between edges; only the edge value moves the state.
        step(1'b0, 1'b0, "R3 zero");
        step(1'b0, 1'b0, "R4 zero");
        @(negedge clk);
        x = 1'b1;
        #0.5;
        check(1'b1, "R7 rise between edges");
        x = 1'b0;
        #0.5;
        check(1'b0, "R7 fall between edges");
        x = 1'b1;
        #0.5;
        check(1'b1, "R7 rise again");
        x = 1'b0; // held at the edge: state stays two-zero
        step(1'b1, 1'b1, "R7 state kept by edge value");
        step(1'b1, 1'b0, "R5 re-armed to idle");

        // Random stream against the model, with occasional reset pulses.
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            x = 1'($urandom % 2);
            rst_n = (($urandom % 32) != 0);
            #1;
            check(rst_n && (m_st == 2'b10) && x, "R2 random vs model");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule